// File: doc/BRIEF.md
# Width-mode and retention sequencer

This block sits between a host-side access controller and an asynchronous static memory. It takes charge of two slow events. One is switching the memory's bus-width pin between byte and word organisation. The other is putting the memory into its low-power data-retention state and bringing it back out. In normal running it passes the controller's select lines straight to the memory. While an event is in progress it drives the select lines itself and pulls `acc_ready` low, so the access controller holds any pending access instead of losing it.

The memory needs long guard intervals, on the order of milliseconds. It must sit deselected for one guard interval before the width pin may change, and for another one afterwards. Entering retention can happen at once. Leaving it needs one guard interval with the supply good and the memory still deselected. The guard length is worked out from the clock frequency and the guard time in milliseconds. There are three ways to hold the memory in retention, and the `RET_MODE` parameter picks one:
- active-high select low;
- active-low select high, with the active-high select held firmly high;
- both byte selects high, with both chip selects left active.

Only the first method lets the address, control and data drivers float, and the block says so on `float_en`. Each event is started by holding a request level until its one-cycle acknowledge appears.

Top module: `width_retention_seq`

## Requirements
- R1: After reset the block is in normal running: `mem_width` equals `WIDTH_RST` (1 = word), `acc_ready` is 1, all acknowledges are 0 and `float_en` is 0.
- R2: In normal running, `mem_cs_n`, `mem_cs`, `mem_lb_n` and `mem_ub_n` equal `ctl_cs_n`, `ctl_cs`, `ctl_lb_n` and `ctl_ub_n`, and `acc_ready` is 1.
- R3: A width request for a new value deselects the memory from the next cycle on: `mem_cs_n`=1, `mem_cs`=0 and both byte selects are 1. `mem_width` keeps its old value for G = (CLK_HZ/1000)*GUARD_MS cycles. It changes only while the memory is deselected.
- R4: After `mem_width` changes, the memory stays deselected for another G cycles. Then `width_ack` pulses for one cycle and normal running resumes in that same cycle.
- R5: A width request whose target equals the current `mem_width` is acknowledged in the next cycle, with no guard interval and no change to the pins.
- R6: A sleep request is acknowledged in the next cycle, and the retention pattern appears in that same cycle. As {cs_n, cs, lb_n, ub_n}: 1,0,1,1 for RET_MODE 0; 1,1,1,1 for RET_MODE 1; 0,1,1,1 for RET_MODE 2.
- R7: `float_en` is 1 only with RET_MODE 0, and only while retained and not yet recovering (sleeping, or waiting for supply).
- R8: A wake request with `supply_ok` high keeps the retention pattern for G cycles with `float_en` 0. Then `wake_ack` pulses and normal running resumes.
- R9: A wake request taken while `supply_ok` is low stays pending with the retention pattern and no acknowledge. Once `supply_ok` rises, the full G-cycle recovery runs.
- R10: If `supply_ok` falls during recovery, the block goes back to waiting. Recovery then restarts from zero when the supply returns.
- R11: While `acc_ready` is 0 the memory is never selected for an access. Requests held during that time are served later and not dropped.
- R12: If sleep and width requests arrive in the same cycle, sleep is served first. The width change runs after the wake.
- R13: A wake request in normal running and a sleep request while retained get no acknowledge and leave the pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_cs_n | input | 1 | Active-low chip select from access controller |
| ctl_cs | input | 1 | Active-high chip select from access controller |
| ctl_lb_n | input | 1 | Low byte select from access controller |
| ctl_ub_n | input | 1 | High byte select from access controller |
| width_req | input | 1 | Width change request level |
| width_tgt | input | 1 | Requested width (1 = word, 0 = byte) |
| width_ack | output | 1 | One-cycle width change done |
| sleep_req | input | 1 | Retention entry request level |
| sleep_ack | output | 1 | One-cycle retention entered |
| wake_req | input | 1 | Retention exit request level |
| wake_ack | output | 1 | One-cycle normal running resumed |
| supply_ok | input | 1 | Supply is at operating level |
| acc_ready | output | 1 | Access controller may run accesses |
| mem_width | output | 1 | Bus-width pin to memory (1 = word) |
| mem_cs_n | output | 1 | Active-low chip select to memory |
| mem_cs | output | 1 | Active-high chip select to memory |
| mem_lb_n | output | 1 | Low byte select to memory |
| mem_ub_n | output | 1 | High byte select to memory |
| float_en | output | 1 | Address, control and data drivers may go high-impedance |

## Verification
Two collisions are the ones that matter.

The first is a sleep request and a width request that reach normal running in the same cycle. The bench raises both levels at once. It expects `sleep_ack` one cycle later with `mem_width` untouched, and no `width_ack` during the whole retention. After the wake it expects the full 2G-cycle width sequence to start without the width request being raised again.

The second is a supply loss that lands inside the recovery count. The bench drops `supply_ok` after the first, middle and last recovery cycle. At each point it expects no acknowledge and a fresh G cycles counted from the moment the supply returns.

// File: rtl/wrs_pkg.sv
// Shared types for the width-mode and retention sequencer.
package wrs_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_WDESEL     = 3'd1,
        ST_WRECOV     = 3'd2,
        ST_SLEEP      = 3'd3,
        ST_WAKE_WAIT  = 3'd4,
        ST_WAKE_RECOV = 3'd5
    } seq_state_t;

    // Memory select pin group
    typedef struct packed {
        logic cs_n;
        logic cs;
        logic lb_n;
        logic ub_n;
    } sel_pins_t;

    // Retention methods
    localparam int RET_HI_SEL_LOW  = 0;
    localparam int RET_LO_SEL_HIGH = 1;
    localparam int RET_BYTES_OFF   = 2;

    localparam sel_pins_t PINS_DESEL = '{cs_n: 1'b1, cs: 1'b0, lb_n: 1'b1, ub_n: 1'b1};

endpackage

// File: rtl/wrs_guard_timer.sv
// Guard interval counter.
// Counts clock cycles while run is high and clears whenever run is low.
// done is high in the last cycle of a LIMIT-cycle interval; the count wraps
// to zero there, so the owner can chain a second interval straight away.
// Assumes LIMIT >= 1.
module wrs_guard_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    // Advance the count while running; clear when idle or at the end of an interval
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/wrs_fsm.sv
// Sequencer state machine.
// Orders width changes, retention entry and recovery, and produces the
// one-cycle acknowledges. Assumes each requester holds its request until it
// sees the acknowledge, then drops it before the following clock edge.
module wrs_fsm
    import wrs_pkg::*;
#(
    parameter logic WIDTH_RST = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       width_req,
    input  logic       width_tgt,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       supply_ok,
    input  logic       tmr_done,
    output seq_state_t state,
    output logic       tmr_run,
    output logic       width_sel,
    output logic       width_ack,
    output logic       sleep_ack,
    output logic       wake_ack
);
    logic tgt_q;

    // Timer runs in guard states; recovery counts only with good supply
    always_comb begin
        tmr_run = (state == ST_WDESEL) || (state == ST_WRECOV) ||
                  ((state == ST_WAKE_RECOV) && supply_ok);
    end

    // State transitions, width register and acknowledge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            width_sel <= WIDTH_RST;
            tgt_q     <= WIDTH_RST;
            width_ack <= 1'b0;
            sleep_ack <= 1'b0;
            wake_ack  <= 1'b0;
        end else begin
            width_ack <= 1'b0;
            sleep_ack <= 1'b0;
            wake_ack  <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (sleep_req) begin
                        state     <= ST_SLEEP;
                        sleep_ack <= 1'b1;
                    end else if (width_req) begin
                        if (width_tgt == width_sel) begin
                            width_ack <= 1'b1;
                        end else begin
                            tgt_q <= width_tgt;
                            state <= ST_WDESEL;
                        end
                    end
                end
                ST_WDESEL: begin
                    if (tmr_done) begin
                        width_sel <= tgt_q;
                        state     <= ST_WRECOV;
                    end
                end
                ST_WRECOV: begin
                    if (tmr_done) begin
                        state     <= ST_RUN;
                        width_ack <= 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (wake_req) state <= supply_ok ? ST_WAKE_RECOV : ST_WAKE_WAIT;
                end
                ST_WAKE_WAIT: begin
                    if (supply_ok) state <= ST_WAKE_RECOV;
                end
                ST_WAKE_RECOV: begin
                    if (!supply_ok) begin
                        state <= ST_WAKE_WAIT;
                    end else if (tmr_done) begin
                        state    <= ST_RUN;
                        wake_ack <= 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assert_wake_supply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |-> $past(supply_ok));
    assert_width_in_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(width_sel) |-> (state == ST_WRECOV));
endmodule

// File: rtl/wrs_pin_mux.sv
// Memory select pin driver.
// In normal running the controller's selects pass through. In guard states
// the memory is fully deselected. In retention the pattern of the chosen
// method is driven. Assumes RET_MODE is 0, 1 or 2.
module wrs_pin_mux
    import wrs_pkg::*;
#(
    parameter int RET_MODE = RET_HI_SEL_LOW
) (
    input  seq_state_t state,
    input  sel_pins_t  ctl,
    output sel_pins_t  mem,
    output logic       acc_ready,
    output logic       float_en
);
    sel_pins_t ret_pins;
    logic      float_ok;

    // Pick the retention pattern and whether floating is allowed
    generate
        if (RET_MODE == RET_LO_SEL_HIGH) begin : g_lo_sel
            assign ret_pins = '{cs_n: 1'b1, cs: 1'b1, lb_n: 1'b1, ub_n: 1'b1};
            assign float_ok = 1'b0;
        end else if (RET_MODE == RET_BYTES_OFF) begin : g_bytes
            assign ret_pins = '{cs_n: 1'b0, cs: 1'b1, lb_n: 1'b1, ub_n: 1'b1};
            assign float_ok = 1'b0;
        end else begin : g_hi_sel
            assign ret_pins = '{cs_n: 1'b1, cs: 1'b0, lb_n: 1'b1, ub_n: 1'b1};
            assign float_ok = 1'b1;
        end
    endgenerate

    // Select the pin source for the current state
    always_comb begin
        mem       = ctl;
        acc_ready = 1'b0;
        float_en  = 1'b0;
        case (state)
            ST_RUN: begin
                mem       = ctl;
                acc_ready = 1'b1;
            end
            ST_WDESEL, ST_WRECOV: mem = PINS_DESEL;
            ST_SLEEP, ST_WAKE_WAIT: begin
                mem      = ret_pins;
                float_en = float_ok;
            end
            ST_WAKE_RECOV: mem = ret_pins;
            default: mem = PINS_DESEL;
        endcase
    end
endmodule

// File: rtl/width_retention_seq.sv
// Width-mode and retention sequencer, top level.
// Guards bus-width changes and retention exit with G-cycle deselected
// intervals, G = (CLK_HZ/1000)*GUARD_MS, and drives the chosen retention
// pattern. Assumes CLK_HZ >= 1000 and request levels held until acknowledged.
module width_retention_seq
    import wrs_pkg::*;
#(
    parameter int   CLK_HZ    = 50_000_000,
    parameter int   GUARD_MS  = 5,
    parameter int   RET_MODE  = RET_HI_SEL_LOW,
    parameter logic WIDTH_RST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_cs_n,
    input  logic ctl_cs,
    input  logic ctl_lb_n,
    input  logic ctl_ub_n,
    input  logic width_req,
    input  logic width_tgt,
    output logic width_ack,
    input  logic sleep_req,
    output logic sleep_ack,
    input  logic wake_req,
    output logic wake_ack,
    input  logic supply_ok,
    output logic acc_ready,
    output logic mem_width,
    output logic mem_cs_n,
    output logic mem_cs,
    output logic mem_lb_n,
    output logic mem_ub_n,
    output logic float_en
);
    localparam int CYC_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int GUARD_CYC  = CYC_PER_MS * ((GUARD_MS > 0) ? GUARD_MS : 1);

    seq_state_t state;
    logic       tmr_run, tmr_done;
    sel_pins_t  ctl_pins, mem_pins;

    assign ctl_pins = '{cs_n: ctl_cs_n, cs: ctl_cs, lb_n: ctl_lb_n, ub_n: ctl_ub_n};
    assign mem_cs_n = mem_pins.cs_n;
    assign mem_cs   = mem_pins.cs;
    assign mem_lb_n = mem_pins.lb_n;
    assign mem_ub_n = mem_pins.ub_n;

    wrs_guard_timer #(.LIMIT(GUARD_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tmr_run),
        .done (tmr_done)
    );

    wrs_fsm #(.WIDTH_RST(WIDTH_RST)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .width_req(width_req),
        .width_tgt(width_tgt),
        .sleep_req(sleep_req),
        .wake_req (wake_req),
        .supply_ok(supply_ok),
        .tmr_done (tmr_done),
        .state    (state),
        .tmr_run  (tmr_run),
        .width_sel(mem_width),
        .width_ack(width_ack),
        .sleep_ack(sleep_ack),
        .wake_ack (wake_ack)
    );

    wrs_pin_mux #(.RET_MODE(RET_MODE)) u_pins (
        .state    (state),
        .ctl      (ctl_pins),
        .mem      (mem_pins),
        .acc_ready(acc_ready),
        .float_en (float_en)
    );

    assert_width_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_width) |-> (mem_cs_n && !mem_cs));
    assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({width_ack, sleep_ack, wake_ack}));
    assert_stall_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ready |-> (mem_cs_n || !mem_cs || (mem_lb_n && mem_ub_n)));
    assert_float_method_R7: assert property (@(posedge clk) disable iff (!rst_n)
        float_en |-> ((RET_MODE == RET_HI_SEL_LOW) && !mem_cs && !acc_ready));
    assert_sleep_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ack |-> !acc_ready);
endmodule

// File: tb/width_retention_seq_tb_top.sv
module width_retention_seq_tb_top;
    localparam int CLK_HZ   = 4000;
    localparam int GUARD_MS = 5;
    localparam int G        = (CLK_HZ / 1000) * GUARD_MS;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic ctl_cs_n = 1'b1, ctl_cs = 1'b0, ctl_lb_n = 1'b1, ctl_ub_n = 1'b1;
    logic width_req = 1'b0, width_tgt = 1'b1, sleep_req = 1'b0, wake_req = 1'b0;
    logic supply_ok = 1'b1;

    logic width_ack, sleep_ack, wake_ack, acc_ready, mem_width;
    logic [4:0] p0, p1, p2;
    logic [5:0] unused_m;

    int n_checks = 0;
    int n_err    = 0;

    width_retention_seq #(.CLK_HZ(CLK_HZ), .GUARD_MS(GUARD_MS), .RET_MODE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_cs_n(ctl_cs_n), .ctl_cs(ctl_cs),
        .ctl_lb_n(ctl_lb_n), .ctl_ub_n(ctl_ub_n), .width_req(width_req),
        .width_tgt(width_tgt), .width_ack(width_ack), .sleep_req(sleep_req),
        .sleep_ack(sleep_ack), .wake_req(wake_req), .wake_ack(wake_ack),
        .supply_ok(supply_ok), .acc_ready(acc_ready), .mem_width(mem_width),
        .mem_cs_n(p0[4]), .mem_cs(p0[3]), .mem_lb_n(p0[2]), .mem_ub_n(p0[1]),
        .float_en(p0[0]));

    width_retention_seq #(.CLK_HZ(CLK_HZ), .GUARD_MS(GUARD_MS), .RET_MODE(1)) dut_m1 (
        .clk(clk), .rst_n(rst_n), .ctl_cs_n(ctl_cs_n), .ctl_cs(ctl_cs),
        .ctl_lb_n(ctl_lb_n), .ctl_ub_n(ctl_ub_n), .width_req(width_req),
        .width_tgt(width_tgt), .width_ack(unused_m[0]), .sleep_req(sleep_req),
        .sleep_ack(unused_m[1]), .wake_req(wake_req), .wake_ack(unused_m[2]),
        .supply_ok(supply_ok), .acc_ready(), .mem_width(),
        .mem_cs_n(p1[4]), .mem_cs(p1[3]), .mem_lb_n(p1[2]), .mem_ub_n(p1[1]),
        .float_en(p1[0]));

    width_retention_seq #(.CLK_HZ(CLK_HZ), .GUARD_MS(GUARD_MS), .RET_MODE(2)) dut_m2 (
        .clk(clk), .rst_n(rst_n), .ctl_cs_n(ctl_cs_n), .ctl_cs(ctl_cs),
        .ctl_lb_n(ctl_lb_n), .ctl_ub_n(ctl_ub_n), .width_req(width_req),
        .width_tgt(width_tgt), .width_ack(unused_m[3]), .sleep_req(sleep_req),
        .sleep_ack(unused_m[4]), .wake_req(wake_req), .wake_ack(unused_m[5]),
        .supply_ok(supply_ok), .acc_ready(), .mem_width(),
        .mem_cs_n(p2[4]), .mem_cs(p2[3]), .mem_lb_n(p2[2]), .mem_ub_n(p2[1]),
        .float_en(p2[0]));

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Expected {cs_n, cs, lb_n, ub_n, float_en} while retained
    function automatic logic [4:0] ret_exp(input int mode, input bit fl);
        case (mode)
            1:       return 5'b11110;
            2:       return 5'b01110;
            default: return {4'b1011, fl};
        endcase
    endfunction

    task automatic check_ret(input string tag, input bit fl);
        chk({tag, " mode0 pins"}, p0, ret_exp(0, fl));
        chk({tag, " mode1 pins"}, p1, ret_exp(1, fl));
        chk({tag, " mode2 pins"}, p2, ret_exp(2, fl));
        chk({tag, " ready"}, acc_ready, 0);
    endtask

    task automatic do_width(input bit tgt);
        bit prev;
        prev      = mem_width;
        width_tgt = tgt;
        width_req = 1'b1;
        if (tgt == prev) begin
            step();
            chk("R5 same-width ack", width_ack, 1);
            chk("R5 width unchanged", mem_width, prev);
            chk("R5 ready kept", acc_ready, 1);
        end else begin
            for (int i = 1; i <= 2 * G + 1; i++) begin
                step();
                if (i <= 2 * G) begin
                    chk("R11 ready low in guard", acc_ready, 0);
                    chk("R3 deselected mode0", p0, 5'b10110);
                    chk("R3 deselected mode2", p2, 5'b10110);
                    chk("R4 no early ack", width_ack, 0);
                    if (i <= G) chk("R3 width held before guard end", mem_width, prev);
                    else        chk("R4 width switched", mem_width, tgt);
                end else begin
                    chk("R4 width ack", width_ack, 1);
                    chk("R4 ready back", acc_ready, 1);
                end
            end
        end
        width_req = 1'b0;
        step();
        chk("R4 ack single cycle", width_ack, 0);
    endtask

    task automatic do_sleep();
        sleep_req = 1'b1;
        step();
        chk("R6 sleep ack", sleep_ack, 1);
        check_ret("R6", 1'b1);
        sleep_req = 1'b0;
        step();
        chk("R6 ack single cycle", sleep_ack, 0);
    endtask

    // Wake already requested and supply good: G cycles then ack
    task automatic wait_recovery(input string tag);
        for (int i = 1; i <= G + 1; i++) begin
            step();
            if (i <= G) begin
                chk({tag, " no early wake ack"}, wake_ack, 0);
                check_ret(tag, 1'b0);
            end else begin
                chk({tag, " wake ack"}, wake_ack, 1);
                chk({tag, " ready back"}, acc_ready, 1);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 width reset", mem_width, 1);
        chk("R1 ready", acc_ready, 1);
        chk("R1 acks", {width_ack, sleep_ack, wake_ack}, 0);
        chk("R1 float", p0[0], 0);

        // R2 pass-through sweep over all select combinations
        for (int v = 0; v < 16; v++) begin
            {ctl_cs_n, ctl_cs, ctl_lb_n, ctl_ub_n} = 4'(v);
            #1;
            chk("R2 pass mode0", p0[4:1], v);
            chk("R2 pass mode1", p1[4:1], v);
            chk("R2 pass mode2", p2[4:1], v);
            chk("R2 ready", acc_ready, 1);
        end
        {ctl_cs_n, ctl_cs, ctl_lb_n, ctl_ub_n} = 4'b0100;

        // R3 R4 R5 width changes both ways and same-width requests
        do_width(1'b1);
        do_width(1'b0);
        do_width(1'b0);
        do_width(1'b1);

        // R6 R7 R8 sleep then wake with good supply
        do_sleep();
        sleep_req = 1'b1;                      // R13 sleep while retained ignored
        repeat (3) begin
            step();
            chk("R13 no sleep ack in retention", sleep_ack, 0);
            check_ret("R13", 1'b1);
        end
        sleep_req = 1'b0;
        wake_req = 1'b1;
        wait_recovery("R8");
        wake_req = 1'b0;
        step();
        chk("R8 ack single cycle", wake_ack, 0);

        // R13 wake in normal running ignored
        wake_req = 1'b1;
        repeat (3) begin
            step();
            chk("R13 no wake ack in run", wake_ack, 0);
            chk("R13 pins pass", p0[4:1], 4'b0100);
        end
        wake_req = 1'b0;

        // R9 wake while supply low stays pending
        do_sleep();
        supply_ok = 1'b0;
        wake_req  = 1'b1;
        repeat (10) begin
            step();
            chk("R9 pending no ack", wake_ack, 0);
            check_ret("R9 waiting", 1'b1);
        end
        supply_ok = 1'b1;
        wait_recovery("R9");
        wake_req = 1'b0;
        step();

        // R10 supply loss at first, middle and last recovery cycle
        for (int s = 0; s < 3; s++) begin
            int k;
            k = (s == 0) ? 1 : (s == 1) ? G / 2 : G;
            do_sleep();
            wake_req = 1'b1;
            repeat (k) step();
            chk("R10 no ack before drop", wake_ack, 0);
            supply_ok = 1'b0;
            step();
            chk("R10 no ack after drop", wake_ack, 0);
            check_ret("R10 back to wait", 1'b1);
            supply_ok = 1'b1;
            wait_recovery("R10");
            wake_req = 1'b0;
            step();
        end

        // R12 sleep beats width; R11 held width request served after wake
        width_tgt = ~mem_width;
        width_req = 1'b1;
        sleep_req = 1'b1;
        step();
        chk("R12 sleep first", sleep_ack, 1);
        chk("R12 width not acked", width_ack, 0);
        chk("R12 width unchanged", mem_width, 1);
        sleep_req = 1'b0;
        repeat (5) begin
            step();
            chk("R11 width pending in sleep", width_ack, 0);
            check_ret("R11", 1'b1);
        end
        wake_req = 1'b1;
        wait_recovery("R12");
        wake_req = 1'b0;
        do_width(1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule